// File: doc/BRIEF.md
# Vectored Interrupt Controller with Stack Guard

This block is the interrupt controller beside a small 8-bit processor core. It serves three sources: a USB engine, which signals any of four bus events, and two timers, which each pulse once on overflow. Software sees a single 8-bit control word. The word holds a global enable, one enable per source and one pending flag per source. A hardware event latches its source's flag. When the global enable, that source's enable and that flag are all set, and the core reports that its return stack has room, the controller raises a take strobe together with the vector of the winning source.

The take strobe is combinational on the registered state and the stack-full input, so the core can branch in the same cycle. On the following clock edge the controller clears the serviced flag and the global enable. Only the program counter is pushed by the core; no status is saved. A return-from-interrupt indication sets the global enable again, and a plain return leaves it as it is. Software can nest interrupts by setting the global enable inside a service routine. A wake output tells a sleeping core that some enabled request is pending, whatever the state of the global enable.

Top module: `vic_irq_ctrl`

## Requirements
- R1: Reset clears every bit of the control word. Its layout is bit 0 global enable, bits 1/2/3 enables for USB/timer 0/timer 1, bits 4/5/6 pending flags for USB/timer 0/timer 1. Bit 7 always reads 0, even after a write of 1.
- R2: A high level on any one of the four USB event inputs sets the USB flag (bit 4) at the next clock edge. A timer overflow pulse sets its flag (bit 5 or bit 6) the same way.
- R3: take_o is high only when the global enable is set, the source's enable and flag are both set, and stack_full_i is low. A pending flag whose enable is clear does not cause a take.
- R4: While take_o is high, vector_o is 0x04 for USB, 0x08 for timer 0 and 0x0C for timer 1. While take_o is low, vector_o is 0x00.
- R5: When several enabled flags are pending, USB wins over timer 0, and timer 0 wins over timer 1.
- R6: At the edge where take_o is high, the winning flag and the global enable are cleared.
- R7: Events that arrive while the global enable is clear are still latched. They are taken once the global enable is set again.
- R8: reti_i sets the global enable at the next edge. ret_i alone leaves the global enable unchanged.
- R9: A write sets and clears flags directly. A hardware event on a flag wins over a write, or a take, that clears that flag in the same cycle.
- R10: wake_o is high whenever any flag is pending with its own enable set, regardless of the global enable and of stack_full_i.
- R11: While stack_full_i is high, no take happens and all pending state is held. A service routine that sets the global enable again allows a nested take once the stack has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| usb_evt_i | input | 4 | USB events: FIFO access, suspend, resume, bus reset |
| tmr0_ovf_i | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf_i | input | 1 | Timer 1 overflow pulse |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 8 | Write data for the control word |
| reg_rdata_o | output | 8 | Current control word |
| stack_full_i | input | 1 | Return stack of the core is full |
| reti_i | input | 1 | Core executes a return-from-interrupt |
| ret_i | input | 1 | Core executes a plain return |
| take_o | output | 1 | Take-interrupt strobe |
| vector_o | output | 8 | Vector address of the taken source |
| wake_o | output | 1 | Enabled request pending |

## Verification
take_o, vector_o and wake_o depend combinationally on the registered state and on stack_full_i, so their values are due in the same cycle as the inputs that drive them. The bench applies each row of inputs on the falling edge and samples these outputs 1 ns later, before the rising edge. The flag, enable and global-enable updates caused by events, writes, takes and returns appear in reg_rdata_o one register stage later. The bench therefore reads the control word 1 ns after the rising edge that follows each row. This same-cycle sampling also covers the cases where an event and a clear collide and where a take coincides with a new event.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int N_SRC    = 3;
  localparam int EN_LSB   = 1;
  localparam int FLG_LSB  = EN_LSB + N_SRC;
  localparam int REG_W    = FLG_LSB + N_SRC + 1;
  localparam int USB_EVTS = 4;
  localparam int VEC_W    = 8;
  localparam int VEC_STEP = 4;

  typedef enum logic [1:0] {
    SRC_USB  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } src_e;
endpackage

// File: rtl/vic_flag_bank.sv
module vic_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic [N-1:0] take_clr_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_val_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    // hw set beats take clear, which beats a software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            flag_o[g] <= 1'b0;
      else if (hw_set_i[g])   flag_o[g] <= 1'b1;
      else if (take_clr_i[g]) flag_o[g] <= 1'b0;
      else if (sw_we_i)       flag_o[g] <= sw_val_i[g];
    end

    // R9
    hw_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[g] |=> flag_o[g]);
    // R6
    take_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_clr_i[g] && !hw_set_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int N        = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             gie_i,
  input  logic             stack_full_i,
  output logic             take_o,
  output logic [N-1:0]     grant_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [N-1:0]     pick;
  logic [VEC_W-1:0] pick_vec;
  logic             found;

  // lowest index wins; vector = (index+1)*step
  always_comb begin
    pick     = '0;
    pick_vec = '0;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found    = 1'b1;
        pick[i]  = 1'b1;
        pick_vec = VEC_W'((i + 1) * VEC_STEP);
      end
    end
  end

  assign take_o   = found && gie_i && !stack_full_i;
  assign grant_o  = take_o ? pick : '0;
  assign vector_o = take_o ? pick_vec : '0;

  // R11
  stack_full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_full_i |-> !take_o);
  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $onehot(grant_o));
  // R5
  top_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && req_i[0]) |-> grant_o[0]);
  // R4
  vec_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (vector_o == '0));
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [USB_EVTS-1:0] usb_evt_i,
  input  logic                tmr0_ovf_i,
  input  logic                tmr1_ovf_i,
  input  logic                reg_we_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic                stack_full_i,
  input  logic                reti_i,
  input  logic                ret_i,
  output logic                take_o,
  output logic [VEC_W-1:0]    vector_o,
  output logic                wake_o
);
  logic             gie_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] flag;
  logic [N_SRC-1:0] hw_set;
  logic [N_SRC-1:0] grant;
  logic             unused_wbit;

  assign unused_wbit = reg_wdata_i[REG_W-1];

  always_comb begin
    hw_set           = '0;
    hw_set[SRC_USB]  = |usb_evt_i;
    hw_set[SRC_TMR0] = tmr0_ovf_i;
    hw_set[SRC_TMR1] = tmr1_ovf_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (reg_we_i) en_q <= reg_wdata_i[EN_LSB +: N_SRC];
      if (take_o)        gie_q <= 1'b0;
      else if (reti_i)   gie_q <= 1'b1;
      else if (reg_we_i) gie_q <= reg_wdata_i[0];
    end
  end

  vic_flag_bank #(.N(N_SRC)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_set_i   (hw_set),
    .take_clr_i (grant),
    .sw_we_i    (reg_we_i),
    .sw_val_i   (reg_wdata_i[FLG_LSB +: N_SRC]),
    .flag_o     (flag)
  );

  vic_arbiter #(.N(N_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (flag & en_q),
    .gie_i        (gie_q),
    .stack_full_i (stack_full_i),
    .take_o       (take_o),
    .grant_o      (grant),
    .vector_o     (vector_o)
  );

  assign wake_o      = |(flag & en_q);
  assign reg_rdata_o = {1'b0, flag, en_q, gie_q};

  // R6
  take_clears_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !reg_rdata_o[0]);
  // R8
  reti_sets_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o) |=> reg_rdata_o[0]);
  // R8
  ret_keeps_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !reti_i && !reg_we_i && !take_o) |=> $stable(gie_q));
  // R10
  wake_leads_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && gie_q && !stack_full_i) |-> take_o);
  // R3
  take_needs_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> wake_o);
endmodule

// File: tb/vic_irq_ctrl_tb.sv
module vic_irq_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] usb_evt_i = '0;
  logic       tmr0_ovf_i = 1'b0, tmr1_ovf_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       stack_full_i = 1'b0, reti_i = 1'b0, ret_i = 1'b0;
  logic       take_o, wake_o;
  logic [7:0] vector_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  vic_irq_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .usb_evt_i(usb_evt_i),
    .tmr0_ovf_i(tmr0_ovf_i), .tmr1_ovf_i(tmr1_ovf_i),
    .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .stack_full_i(stack_full_i), .reti_i(reti_i), .ret_i(ret_i),
    .take_o(take_o), .vector_o(vector_o), .wake_o(wake_o)
  );

  typedef struct packed {
    logic [7:0] tag;
    logic       we;
    logic [7:0] wd;
    logic [3:0] usb;
    logic       t0, t1, sf, reti, ret;
    logic       e_take;
    logic [7:0] e_vec;
    logic       e_wake;
    logic [7:0] e_reg;
  } row_t;

  localparam int NROWS = 22;
  localparam row_t TBL [NROWS] = '{
    '{8'd1,  1'b1, 8'h0F, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h0F}, // R1 enable all
    '{8'd2,  1'b0, 8'h00, 4'h0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h4F}, // R2 timer1 pulse
    '{8'd4,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h0C,1'b1,8'h0E}, // R4 R6 take timer1
    '{8'd7,  1'b0, 8'h00, 4'h4, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h3E}, // R7 events while gie clear
    '{8'd7,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h3E}, // R7 R10 held, wake
    '{8'd8,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,8'h00,1'b1,8'h3F}, // R8 reti
    '{8'd11, 1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h3F}, // R11 stack full
    '{8'd5,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h04,1'b1,8'h2E}, // R5 usb over timer0
    '{8'd8,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0,8'h00,1'b1,8'h2E}, // R8 plain ret
    '{8'd8,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,8'h00,1'b1,8'h2F}, // R8 reti
    '{8'd4,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h08,1'b1,8'h0E}, // R4 take timer0
    '{8'd9,  1'b1, 8'h71, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h71}, // R9 sw sets flags
    '{8'd3,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h71}, // R3 no enables
    '{8'd9,  1'b1, 8'h01, 4'h0, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h21}, // R9 hw beats clear
    '{8'd1,  1'b1, 8'hFF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h7F}, // R1 bit7 zero
    '{8'd5,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h04,1'b1,8'h6E}, // R5 all pending
    '{8'd11, 1'b1, 8'h6F, 4'h0, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h6F}, // R11 nest enable
    '{8'd11, 1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h6F}, // R11 held
    '{8'd5,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,8'h08,1'b1,8'h4E}, // R5 nested timer0
    '{8'd8,  1'b0, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,8'h00,1'b1,8'h4F}, // R8 reti
    '{8'd9,  1'b0, 8'h00, 4'h0, 1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,8'h0C,1'b1,8'h4E}, // R9 event during take
    '{8'd1,  1'b1, 8'h00, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h00}  // R1 clear all
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    usb_evt_i = '0; tmr0_ovf_i = 1'b0; tmr1_ovf_i = 1'b0;
    reg_we_i = 1'b0; reg_wdata_i = '0; stack_full_i = 1'b0;
    reti_i = 1'b0; ret_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "reset reg", reg_rdata_o, 8'h00);
    chk("R1", "reset take", take_o, 0);
    chk("R10", "reset wake", wake_o, 0);
    rst_ni = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      string tg;
      @(negedge clk_i);
      reg_we_i = TBL[r].we; reg_wdata_i = TBL[r].wd; usb_evt_i = TBL[r].usb;
      tmr0_ovf_i = TBL[r].t0; tmr1_ovf_i = TBL[r].t1; stack_full_i = TBL[r].sf;
      reti_i = TBL[r].reti; ret_i = TBL[r].ret;
      tg = $sformatf("R%0d row%0d", TBL[r].tag, r);
      #1;
      chk(tg, "take", take_o, TBL[r].e_take);
      chk(tg, "vector", vector_o, TBL[r].e_vec);
      chk(tg, "wake", wake_o, TBL[r].e_wake);
      @(posedge clk_i); #1;
      chk(tg, "reg", reg_rdata_o, TBL[r].e_reg);
    end

    // R2 each USB event line alone sets the USB flag
    for (int b = 0; b < 4; b++) begin
      @(negedge clk_i);
      idle_inputs();
      usb_evt_i = 4'(1 << b);
      @(posedge clk_i); #1;
      chk("R2", "usb line flag", reg_rdata_o, 8'h10);
      @(negedge clk_i);
      idle_inputs();
      reg_we_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R2", "flag cleared by write", reg_rdata_o, 8'h00);
    end

    // R1 asynchronous reset mid-run
    @(negedge clk_i);
    idle_inputs();
    reg_we_i = 1'b1; reg_wdata_i = 8'h7F;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    idle_inputs();
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "async reset reg", reg_rdata_o, 8'h00);
    chk("R1", "async reset take", take_o, 0);
    chk("R10", "async reset wake", wake_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule